// File: doc/BRIEF.md
# SPI Slave Shift Interface

This block is the target side of an SPI link. The master supplies the serial clock and an active-low chip select. While the select is low, the block moves one bit in each direction per serial clock cycle. It sends a word that a local user has loaded, and at the same time it builds a word from the incoming data line. All bus pins are oversampled in the block's own system clock domain. No serial clock edge ever clocks a flop directly. Clock polarity and clock phase are chosen by two configuration inputs, which must only change while the select is high.

When a word completes, it goes to a single holding buffer, and a one-cycle valid pulse flags it. The user then acknowledges it with a read strobe. If another word completes before that acknowledgement, the new word is dropped and a sticky overrun flag is raised. The user clears this flag with its own strobe. The outgoing word is taken from a transmit holding register at every word boundary. If the user has not loaded a new value, the last loaded value is sent again. The serial clock must run at one eighth of the system clock or slower, so that the returned bit settles within half a serial clock period after the three system clock cycles of synchronizer and edge-detect latency.

Top module: `spi_slv_top`

## Requirements
- R1: After a synchronous active-low reset, spi_miso_oe_o, rx_valid_o and overrun_o are 0 and rx_data_o is all zeros.
- R2: While spi_cs_n_i is high (inactive), spi_miso_oe_o is 0, and edges on spi_sck_i and spi_mosi_i produce no delivered word and leave no partial bits behind.
- R3: With polarity 0 and phase 0, the first outgoing bit is driven from the select falling, data is sampled on the rising serial clock edge and the returned bit changes on the falling edge; words go most significant bit first on both lines.
- R4: With phase 1, the returned bit changes on the leading serial clock edge and input is sampled on the trailing edge; polarity 1 makes the idle level high and swaps which physical edge is leading; all four modes carry correct words both ways.
- R5: Every DATA_W serial clock cycles one word completes; rx_valid_o is then high for exactly one system clock cycle, with rx_data_o equal to the incoming word, and rx_data_o does not change at any other time.
- R6: The outgoing word is captured from the transmit holding register (written by tx_load_i with tx_data_i) at the select falling and at each word boundary; without a new load the same value is sent again.
- R7: A word that completes while the buffer holds an unacknowledged word (no rx_read_i since the last rx_valid_o, and none in the same cycle) is discarded: rx_data_o keeps the old word, no valid pulse occurs, and overrun_o goes to 1.
- R8: overrun_o stays 1 through later words and reads until overrun_clr_i is pulsed, after which it reads 0.
- R9: A select rising before a word is complete aborts that word: nothing is delivered, and the next select starts again at bit 0 with the transmit word reloaded.
- R10: Several words can be sent back to back inside one select assertion, each delivered in turn, with the second word taking the transmit value loaded during the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol_i | input | 1 | Serial clock idle level |
| cfg_cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| spi_sck_i | input | 1 | Serial clock from the master |
| spi_cs_n_i | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| spi_miso_oe_o | output | 1 | Output enable for spi_miso_o, high while selected |
| tx_data_i | input | DATA_W | Next outgoing word |
| tx_load_i | input | 1 | Writes tx_data_i into the transmit holding register |
| rx_data_o | output | DATA_W | Last delivered incoming word |
| rx_valid_o | output | 1 | One-cycle pulse when a word is delivered |
| rx_read_i | input | 1 | Acknowledges the held word |
| overrun_o | output | 1 | Sticky flag for a dropped word |
| overrun_clr_i | input | 1 | Clears overrun_o |

## Verification
Words go in both directions in all four polarity/phase modes, with distinct bit patterns each way. A mode that samples or drives on the wrong edge then shows up as a shifted or inverted word rather than passing by chance. Serial clock and data noise while deselected, a three-bit aborted word, and two words under one select separate stray bit counting from correct word framing. A sequence that leaves a word unread, then reads without clearing and then clears, separates a discarded word from an overwritten one, and a sticky flag from a self-clearing one. A behavioural model predicts the valid pulse, the held word, the overrun flag and the output enable on every system clock. Any error in the pin-to-output latency is therefore caught as well.

// File: rtl/spi_slv_pkg.sv
// Shared types for the SPI slave shift interface.
package spi_slv_pkg;
    // Per-cycle action strobes decoded from the synchronized serial clock.
    typedef struct packed {
        logic sample;   // capture incoming bit
        logic drive;    // present next outgoing bit
    } spi_strobe_t;
endpackage

// File: rtl/spi_slv_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous input pins.
// Assumes each bit is independently tolerant of one cycle of skew.
module spi_slv_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
// Decodes serial clock edges into sample/drive strobes for the selected
// polarity and phase, and flags the start of a selection.
// Assumes synchronized inputs and configuration stable while selected.
module spi_slv_edge
    import spi_slv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpol_i,
    input  logic        cpha_i,
    input  logic        sck_s_i,
    input  logic        cs_n_s_i,
    output logic        cs_act_o,
    output logic        cs_start_o,
    output spi_strobe_t strobe_o
);
    logic sck_q, cs_act_q;
    logic rise, fall, lead, trail;

    // Remember last synchronized clock and select levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_act_q <= 1'b0;
        end else begin
            sck_q    <= sck_s_i;
            cs_act_q <= ~cs_n_s_i;
        end
    end

    // Map physical edges to leading/trailing and then to actions.
    always_comb begin
        rise            = sck_s_i & ~sck_q;
        fall            = ~sck_s_i & sck_q;
        lead            = cpol_i ? fall : rise;
        trail           = cpol_i ? rise : fall;
        cs_act_o        = ~cs_n_s_i;
        cs_start_o      = cs_act_o & ~cs_act_q;
        strobe_o.sample = cs_act_o & (cpha_i ? trail : lead);
        strobe_o.drive  = cs_act_o & (cpha_i ? lead : trail);
    end
endmodule

// File: rtl/spi_slv_shift.sv
// Bit counter and the two shift registers. Loads the outgoing word at
// select start and word end, and reports a completed incoming word.
// Assumes sample and drive strobes never fall in the same cycle.
module spi_slv_shift
    import spi_slv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              cs_start_i,
    input  logic              cpha_i,
    input  spi_strobe_t       strobe_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_word_i,
    output logic              miso_o,
    output logic              frame_done_o,
    output logic [DATA_W-1:0] frame_word_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_sh_q, tx_sh_q;
    logic              miso_q;

    // Count bits, shift data both ways, reload at word boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            miso_q    <= 1'b0;
        end else if (!cs_act_i) begin
            bit_cnt_q <= '0;
        end else if (cs_start_i) begin
            bit_cnt_q <= '0;
            miso_q    <= tx_word_i[DATA_W-1];
            tx_sh_q   <= cpha_i ? tx_word_i : (tx_word_i << 1);
        end else begin
            if (strobe_i.sample) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_i};
                if (bit_cnt_q == LAST_BIT) begin
                    bit_cnt_q <= '0;
                    tx_sh_q   <= tx_word_i;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
            if (strobe_i.drive) begin
                miso_q  <= tx_sh_q[DATA_W-1];
                tx_sh_q <= tx_sh_q << 1;
            end
        end
    end

    // Word completion is the last sample of a word.
    always_comb begin
        frame_done_o = cs_act_i & ~cs_start_i & strobe_i.sample & (bit_cnt_q == LAST_BIT);
        frame_word_o = {rx_sh_q[DATA_W-2:0], mosi_i};
    end

    assign miso_o = miso_q;

    AST_MISO_ON_START: assert property (@(posedge clk) disable iff (!rst_n) cs_start_i |=> (miso_o == $past(tx_word_i[DATA_W-1]))); // R3
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_act_i) |=> (bit_cnt_q == '0)); // R9
endmodule

// File: rtl/spi_slv_top.sv
// SPI slave: synchronizes the bus pins, exchanges DATA_W-bit words MSB
// first, keeps a transmit holding register and a one-word receive buffer
// with overrun detection. Assumes SCK at most 1/8 of clk.
module spi_slv_top
    import spi_slv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic              spi_sck_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    output logic              spi_miso_oe_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_read_i,
    output logic              overrun_o,
    input  logic              overrun_clr_i
);
    localparam int PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_act, cs_start, frame_done;
    spi_strobe_t       strobe;
    logic [DATA_W-1:0] frame_word, tx_hold_q, rx_data_q;
    logic              rx_valid_q, rx_full_q, ovr_q;

    spi_slv_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({spi_cs_n_i, spi_sck_i, spi_mosi_i}),
        .q_o(pins_s)
    );

    spi_slv_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .cpol_i(cfg_cpol_i), .cpha_i(cfg_cpha_i),
        .sck_s_i(pins_s[1]), .cs_n_s_i(pins_s[2]),
        .cs_act_o(cs_act), .cs_start_o(cs_start), .strobe_o(strobe)
    );

    spi_slv_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_act_i(cs_act), .cs_start_i(cs_start), .cpha_i(cfg_cpha_i),
        .strobe_i(strobe), .mosi_i(pins_s[0]), .tx_word_i(tx_hold_q),
        .miso_o(spi_miso_o), .frame_done_o(frame_done), .frame_word_o(frame_word)
    );

    // Transmit holding register written by the local user.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_hold_q <= '0;
        else if (tx_load_i) tx_hold_q <= tx_data_i;
    end

    // Receive buffer: deliver, acknowledge, or drop with overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_q  <= '0;
            rx_valid_q <= 1'b0;
            rx_full_q  <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (rx_read_i)     rx_full_q <= 1'b0;
            if (overrun_clr_i) ovr_q     <= 1'b0;
            if (frame_done) begin
                if (rx_full_q && !rx_read_i) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_data_q  <= frame_word;
                    rx_valid_q <= 1'b1;
                    rx_full_q  <= 1'b1;
                end
            end
        end
    end

    assign spi_miso_oe_o = cs_act;
    assign rx_data_o     = rx_data_q;
    assign rx_valid_o    = rx_valid_q;
    assign overrun_o     = ovr_q;

    AST_VALID_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |-> $past(cs_act)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |=> !rx_valid_o); // R5
    AST_DISCARD_FULL: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && rx_full_q && !rx_read_i) |=> (!rx_valid_o && overrun_o)); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid_o |-> $stable(rx_data_o)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun_o && !overrun_clr_i) |=> overrun_o); // R8
endmodule

// File: tb/spi_slv_top_tb_top.sv
// Bench: acts as SPI master and user; a behavioural model predicts the
// valid pulse, held word, overrun flag and output enable every clock.
module spi_slv_top_tb_top;
    localparam int H = 8;   // system clocks per serial half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_load = 1'b0, rx_read = 1'b0, ovr_clr = 1'b0;
    logic miso, miso_oe, rx_valid, overrun;
    logic [7:0] rx_data;

    int total = 0, bad = 0, cyc = 0, valid_seen = 0;
    bit done = 1'b0, model_on = 1'b0;

    // behavioural model state
    int pend_due = -1, read_due = -1, clr_due = -1, oe_due = -1;
    logic [7:0] pend_word, exp_data = '0;
    bit exp_valid = 0, exp_full = 0, exp_ovr = 0, exp_oe = 0, oe_val = 0;

    spi_slv_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cpol_i(cpol), .cfg_cpha_i(cpha),
        .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
        .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
        .tx_data_i(tx_data), .tx_load_i(tx_load),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_read_i(rx_read),
        .overrun_o(overrun), .overrun_clr_i(ovr_clr)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock model update and comparison.
    always @(negedge clk) begin
        if (model_on) begin
            exp_valid = 0;
            if (cyc == pend_due) begin
                if (exp_full) exp_ovr = 1;
                else begin exp_data = pend_word; exp_valid = 1; exp_full = 1; end
            end
            if (cyc == read_due) exp_full = 0;
            if (cyc == clr_due) exp_ovr = 0;
            if (cyc == oe_due) exp_oe = oe_val;
            if (rx_valid) valid_seen++;
            chk(rx_valid == exp_valid, "R5", "rx_valid", int'(rx_valid), int'(exp_valid));
            chk(rx_data == exp_data, "R5", "rx_data", int'(rx_data), int'(exp_data));
            chk(overrun == exp_ovr, "R7 R8", "overrun", int'(overrun), int'(exp_ovr));
            chk(miso_oe == exp_oe, "R2", "miso_oe", int'(miso_oe), int'(exp_oe));
        end
    end

    task automatic cs_low();
        cs_n = 1'b0; oe_due = cyc + 2; oe_val = 1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_high();
        cs_n = 1'b1; oe_due = cyc + 2; oe_val = 0;
        repeat (H) @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol = pol; cpha = pha; sck = pol;
        repeat (H) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic do_read();
        rx_read = 1'b1; read_due = cyc + 1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic do_clr();
        ovr_clr = 1'b1; clr_due = cyc + 1;
        @(negedge clk); ovr_clr = 1'b0;
    endtask

    // Master side of one word, MSB first; nbits < 8 aborts early.
    task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                repeat (H) @(negedge clk);
                got[7-i] = miso; sck = ~sck;
                if (i == 7) begin pend_due = cyc + 3; pend_word = mo; end
                repeat (H) @(negedge clk);
                sck = ~sck;
            end else begin
                sck = ~sck; mosi = mo[7-i];
                repeat (H) @(negedge clk);
                got[7-i] = miso; sck = ~sck;
                if (i == 7) begin pend_due = cyc + 3; pend_word = mo; end
                repeat (H) @(negedge clk);
            end
        end
        repeat (H) @(negedge clk);
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] mode_tx [4];
        int vs;
        mode_tx[0] = 8'h00; mode_tx[1] = 8'hB2; mode_tx[2] = 8'h4E; mode_tx[3] = 8'hD9;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(miso_oe == 0 && rx_valid == 0 && overrun == 0 && rx_data == 0, "R1", "reset outputs",
            {miso_oe, rx_valid, overrun, rx_data}, 0);
        rst_n = 1'b1; model_on = 1;
        repeat (4) @(negedge clk);

        // R2: noise while deselected
        vs = valid_seen;
        for (int k = 0; k < 20; k++) begin
            sck = ~sck; mosi = k[0] ^ k[2];
            repeat (H) @(negedge clk);
        end
        sck = 1'b0; repeat (H) @(negedge clk);
        chk(valid_seen == vs, "R2", "words while deselected", valid_seen - vs, 0);

        // R3: mode 0 word, MSB first both ways
        load(8'h3C);
        cs_low(); xfer(8'hA5, 8, got); cs_high();
        chk(got == 8'h3C, "R3", "mode0 miso word", got, 8'h3C);
        chk(rx_data == 8'hA5, "R2", "first word after noise", rx_data, 8'hA5);
        do_read();

        // R6: no new load, same word repeats
        cs_low(); xfer(8'h5A, 8, got); cs_high();
        chk(got == 8'h3C, "R6", "repeated tx word", got, 8'h3C);
        do_read();

        // R10: two words in one select, reload during the first
        load(8'h11);
        cs_low(); load(8'h22);
        xfer(8'hC3, 8, got);
        chk(got == 8'h11, "R10", "first word of burst", got, 8'h11);
        do_read();
        xfer(8'h96, 8, got);
        chk(got == 8'h22, "R10", "second word of burst", got, 8'h22);
        chk(rx_data == 8'h96, "R10", "second rx word", rx_data, 8'h96);
        cs_high(); do_read();

        // R4: remaining polarity/phase modes
        for (int m = 1; m < 4; m++) begin
            set_mode(m[1], m[0]);
            load(mode_tx[m]);
            cs_low(); xfer(8'h69 ^ 8'(m), 8, got); cs_high();
            chk(got == mode_tx[m], "R4", "miso word in mode", got, mode_tx[m]);
            chk(rx_data == (8'h69 ^ 8'(m)), "R4", "rx word in mode", rx_data, 8'h69 ^ 8'(m));
            do_read();
        end

        // R7: unread word, next one discarded
        set_mode(1'b0, 1'b0);
        load(8'h0F);
        cs_low(); xfer(8'hE7, 8, got); xfer(8'h18, 8, got); cs_high();
        chk(overrun == 1, "R7", "overrun after drop", overrun, 1);
        chk(rx_data == 8'hE7, "R7", "held word kept", rx_data, 8'hE7);
        do_read();

        // R8: sticky through a good word, cleared by strobe
        cs_low(); xfer(8'h42, 8, got); cs_high();
        chk(overrun == 1, "R8", "overrun still set", overrun, 1);
        chk(rx_data == 8'h42, "R8", "word after overrun", rx_data, 8'h42);
        do_read(); do_clr(); @(negedge clk);
        chk(overrun == 0, "R8", "overrun cleared", overrun, 0);

        // R9: abort after three bits, then a clean word
        load(8'hA9);
        vs = valid_seen;
        cs_low(); xfer(8'h81, 3, got); cs_high();
        chk(valid_seen == vs, "R9", "no delivery on abort", valid_seen - vs, 0);
        cs_low(); xfer(8'h6D, 8, got); cs_high();
        chk(got == 8'hA9, "R9", "tx after abort", got, 8'hA9);
        chk(rx_data == 8'h6D, "R9", "rx after abort", rx_data, 8'h6D);
        do_read();
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule